// File: doc/BRIEF.md
# Edge-Coded Channel Transmitter with Refresh

This block is the sending end of one logic line that crosses an isolation boundary. A raw logic input is synchronized, then accepted only after it has held a new value for a minimum number of clock cycles. Every accepted change is sent as a one-cycle command on a two-wire output: `set_o` orders the far side to drive high, `clr_o` orders it to drive low. Commands carry changes, not the level itself.

A receiver that misses a command, or comes out of reset later than the sender, needs a way back to the right level. A background timer therefore resends the current level whenever no command has gone out for a fixed number of cycles. After reset the block stays silent until the first refresh. While the local enable is low, the block ignores its input and keeps the last accepted level. Refreshes of that held level continue.

Top module: `edge_cmd_tx`

## Requirements
- R1: While `rst_n` is low, `set_o` and `clr_o` are both 0, and the accepted level is low.
- R2: With the accepted level low and `en` high, if `din` is sampled high at FILT_CYCLES consecutive rising edges k .. k+FILT_CYCLES-1, then `set_o` is 1 for exactly one cycle, following edge k+FILT_CYCLES+1.
- R3: A falling change is handled as in R2 and with the same latency, but it is reported on `clr_o`.
- R4: A `din` pulse that lasts fewer than FILT_CYCLES cycles produces no command, and it leaves the accepted level unchanged.
- R5: A refresh command is sent when REFRESH_CYCLES rising edges have passed since the last command (or since reset). It is `set_o` if the accepted level is high and `clr_o` if it is low.
- R6: The refresh interval restarts from zero on every command, whether the command came from a change or from a refresh.
- R7: While `en` is low, changes on `din` are ignored and the accepted level is held. Refreshes of the held level continue on schedule.
- R8: `set_o` and `clr_o` are never 1 in the same cycle.
- R9: After reset, no command is sent before the first refresh at edge REFRESH_CYCLES, even if `din` changes before then. That first refresh reports the level accepted by then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable; when low, the input is frozen |
| din | input | 1 | Asynchronous logic input |
| set_o | output | 1 | One-cycle command: far side goes high |
| clr_o | output | 1 | One-cycle command: far side goes low |

## Verification
The inline properties assume `rst_n` is held low for several cycles before it is first released. They also assume that `en` and `din` change only between clock edges. The bench therefore drives `din` and `en` on the falling edge, and it asserts and releases reset just after a rising edge. Random stimulus mixes hold times both shorter and longer than the filter length, and it drops the enable at times. This exercises glitch rejection, frozen windows and refresh collisions. A reference model compares both command wires on every cycle.

// File: rtl/edge_cmd_tx.sv
module edge_cmd_tx #(
  parameter int REFRESH_CYCLES = 500,
  parameter int FILT_CYCLES    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic set_o,
  output logic clr_o
);
  localparam int TW = $clog2(REFRESH_CYCLES + 1);
  localparam int FW = $clog2(FILT_CYCLES + 1);

  logic          s1, s2, lvl, armed;
  logic [FW-1:0] fcnt;
  logic [TW-1:0] tmr;

  wire differ   = en && (s2 != lvl);
  wire accept   = differ && (fcnt == FW'(FILT_CYCLES - 1));
  wire tick     = (tmr == TW'(REFRESH_CYCLES - 1));
  wire edge_cmd = accept && armed;
  wire send     = edge_cmd || tick;
  wire nxt_lvl  = accept ? s2 : lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      lvl  <= 1'b0;
    end else begin
      fcnt <= (!differ || accept) ? '0 : fcnt + 1'b1;
      lvl  <= nxt_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr   <= '0;
      armed <= 1'b0;
      set_o <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      tmr   <= send ? '0 : tmr + 1'b1;
      armed <= armed | tick;
      set_o <= send && nxt_lvl;
      clr_o <= send && !nxt_lvl;
    end
  end

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_o, clr_o}));
  p_set_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> !set_o);
  p_clr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !clr_o);
  p_set_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> lvl);
  p_clr_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> !lvl);
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> lvl == $past(lvl));
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(set_o || clr_o));
endmodule

// File: tb/edge_cmd_tx_tb_top.sv
module edge_cmd_tx_tb_top;
  localparam int REFRESH = 40;
  localparam int FILT    = 3;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, din = 1'b0;
  logic set_o, clr_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  edge_cmd_tx #(.REFRESH_CYCLES(REFRESH), .FILT_CYCLES(FILT)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .set_o(set_o), .clr_o(clr_o));

  // reference model, updated at each rising edge
  bit p1, p2, mlvl, marmed, had_edge, exp_set, exp_clr;
  int unsigned run, since, en_low_age;
  string tag = "R1";

  always @(posedge clk) begin
    bit syn, acc, edgec, tick;
    if (!rst_n) begin
      p1 = 0; p2 = 0; mlvl = 0; marmed = 0; had_edge = 0;
      run = 0; since = 0; en_low_age = 100;
      exp_set = 0; exp_clr = 0; tag = "R1";
    end else begin
      syn = p2; p2 = p1; p1 = din; acc = 0;
      en_low_age = en ? en_low_age + 1 : 0;
      if (en && syn != mlvl) run++; else run = 0;
      if (run == FILT) begin acc = 1; mlvl = syn; run = 0; end
      since++;
      tick  = (since == REFRESH);
      edgec = acc && marmed;
      exp_set = (edgec || tick) && mlvl;
      exp_clr = (edgec || tick) && !mlvl;
      if (edgec)                        tag = mlvl ? "R2" : "R3";
      else if (tick)                    tag = had_edge ? "R6" : "R5";
      else if (!marmed)                 tag = "R9";
      else if (en_low_age < FILT + 3)   tag = "R7";
      else                              tag = "R4";
      if (edgec) had_edge = 1; else if (tick) had_edge = 0;
      marmed |= tick;
      if (edgec || tick) since = 0;
    end
  end

  always @(negedge clk) begin
    bit es, ec;
    es = rst_n ? exp_set : 1'b0;
    ec = rst_n ? exp_clr : 1'b0;
    n_chk++;
    if (set_o !== es || clr_o !== ec) begin
      n_bad++;
      $display("FAIL %s: set=%0b clr=%0b expected set=%0b clr=%0b at %0t",
               rst_n ? tag : "R1", set_o, clr_o, es, ec, $time);
    end
    n_chk++;
    if (set_o === 1'b1 && clr_o === 1'b1) begin
      n_bad++;
      $display("FAIL R8: set=1 clr=1 expected at most one at %0t", $time);
    end
  end

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hold(bit v, bit e, int n);
    din = v; en = e;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    hold(1, 1, 90);                       // R9 early high, R5 refreshes
    hold(0, 1, 12); hold(1, 1, 12);       // R3, R2
    hold(0, 1, 50);                       // R6 restart after change
    for (int w = 1; w < FILT; w++) begin  // R4 glitches
      hold(1, 1, w); hold(0, 1, 10);
    end
    hold(0, 1, 2);                        // R4 boundary: exactly FILT wide
    hold(1, 1, FILT); hold(0, 1, 15);
    hold(0, 0, 2);                        // R7 frozen window
    for (int i = 0; i < 30; i++) hold(1'($urandom % 2), 0, 1 + $urandom % 6);
    hold(1, 1, 50);
    do_reset();                           // second reset, input high
    hold(1, 1, 60);
    for (int i = 0; i < 500; i++) begin
      int n;
      n = ($urandom % 6 == 0) ? 1 + $urandom % 60 : 1 + $urandom % 8;
      hold(1'($urandom % 2), ($urandom % 8) != 0, n);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule